// File: doc/BRIEF.md
# Flash Block-Lock Command and Status Controller

This block models the command front end of a small NOR flash array. Software issues bus writes that carry a command byte, an address and a data byte. The block decodes them into program, block erase, erase of every unlocked block, block lock, write-protect set and clear, status clear and read-mode selection. Each block has its own lock bit, and a single write-protect flag applies to the whole array. While write protect is on, the lock bits are enforced. A refused operation raises the ready bit and both error flags. Software uses this to probe the lock state of a block by writing FFh to it.

Program and erase run against a small register file. Each one holds the ready bit low for a fixed number of clock cycles. The 8-bit status byte reports ready, the erase and write error flags, and a supply-low/abort flag. The error flags stay set until software clears them. One read port returns either the status byte or the array word at the current address, depending on the last read-mode command.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset every block is locked, write protect is on, ready_o is 1, reads return array data (every word FFh), and the status byte reads 80h.
- R2: Status layout: bit 7 = ready, bit 5 = erase error, bit 4 = write error, bit 3 = supply-low/abort. Bit 6 and bits 2:0 always read 0.
- R3: Program is two writes: 10h, then address and data. The addressed word becomes its old value AND the data. ready_o is 0 for exactly BUSY_CYCLES cycles, starting on the cycle after the second write.
- R4: Block erase is two writes: 20h, then any address inside the block. Every word of that block becomes FFh and the block's lock bit clears. The busy time is the same as for a program.
- R5: While write protect is on, a program or block erase aimed at a locked block changes no data, never drops ready, and leaves the status at B0h (bits 7, 5 and 4 set). The same FFh write to an unlocked block runs normally.
- R6: Command 47h turns write protect off, so program and erase are accepted on locked blocks. Command 57h turns it back on.
- R7: Lock is two writes: 77h, then an address in the block. It sets that block's lock bit, so later writes to the block are refused while write protect is on.
- R8: Command A7h erases to FFh only the blocks whose lock bit is clear. It runs even with write protect on and other blocks locked, and it busies for BUSY_CYCLES cycles.
- R9: A first-cycle code outside the command set sets both error flags. Error flags stay set across later commands until 50h clears bits 5, 4 and 3.
- R10: While busy, every write is ignored except 70h. A write-protect change, a read-mode change or a command start made during busy has no effect.
- R11: If vpp_low_i is 1 when a program or erase would start, the operation is aborted without busy and without a data change. Bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R12: 70h selects status reads and FFh selects array reads. The second write of a program, erase or lock also selects status reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Word address; upper bits select the block |
| wdata_i | input | 8 | Command byte or program data |
| vpp_low_i | input | 1 | Program supply below threshold |
| rdata_o | output | 8 | Status byte or array word at addr_i |
| ready_o | output | 1 | 1 when no program or erase is running |

## Verification
Status flags, the read mode and lock refusals are registered on the edge that takes the write. They are due one cycle later, and the bench samples them at the falling edge right after each write completes. ready_o falls on the cycle after the write that starts an operation and stays low for exactly BUSY_CYCLES cycles. The bench counts the low falling-edge samples from that first cycle and compares the count with the parameter. Array contents are read only after ready has returned, using an array-read command followed by a settled combinational read at the chosen address.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_PROG      = 8'h10;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_ALL = 8'hA7;
  localparam logic [7:0] CMD_LOCK      = 8'h77;
  localparam logic [7:0] CMD_WP_SET    = 8'h57;
  localparam logic [7:0] CMD_WP_CLR    = 8'h47;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_RD_STAT   = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;

  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE, PEND_LOCK} pend_e;

  typedef struct packed {
    logic prog;
    logic erase;
    logic erase_all;
    logic lock;
    logic wp_set;
    logic wp_clr;
    logic clr_stat;
    logic bad;
  } req_t;
endpackage

// File: rtl/flc_cmd_fsm.sv
module flc_cmd_fsm
  import flc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  output req_t       req_o,
  output logic       pend_o,
  output logic       rd_status_o
);
  pend_e pend_q;
  logic  rd_status_q;
  logic  take;

  assign take        = wr_en_i && !busy_i;
  assign pend_o      = (pend_q != PEND_NONE);
  assign rd_status_o = rd_status_q;

  always_comb begin
    req_o = '0;
    if (take) begin
      if (pend_q != PEND_NONE) begin
        unique case (pend_q)
          PEND_PROG:  req_o.prog  = 1'b1;
          PEND_ERASE: req_o.erase = 1'b1;
          PEND_LOCK:  req_o.lock  = 1'b1;
          default:    ;
        endcase
      end else begin
        case (wdata_i)
          CMD_ERASE_ALL: req_o.erase_all = 1'b1;
          CMD_WP_SET:    req_o.wp_set    = 1'b1;
          CMD_WP_CLR:    req_o.wp_clr    = 1'b1;
          CMD_CLR_STAT:  req_o.clr_stat  = 1'b1;
          CMD_PROG, CMD_ERASE, CMD_LOCK, CMD_RD_STAT, CMD_RD_ARRAY: ;
          default:       req_o.bad       = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= PEND_NONE;
      rd_status_q <= 1'b0;
    end else if (wr_en_i) begin
      if (busy_i) begin
        if (wdata_i == CMD_RD_STAT) rd_status_q <= 1'b1;
      end else if (pend_q != PEND_NONE) begin
        pend_q      <= PEND_NONE;
        rd_status_q <= 1'b1;
      end else begin
        case (wdata_i)
          CMD_PROG:      pend_q <= PEND_PROG;
          CMD_ERASE:     pend_q <= PEND_ERASE;
          CMD_LOCK:      pend_q <= PEND_LOCK;
          CMD_RD_STAT:   rd_status_q <= 1'b1;
          CMD_RD_ARRAY:  rd_status_q <= 1'b0;
          CMD_ERASE_ALL: rd_status_q <= 1'b1;
          CMD_WP_SET, CMD_WP_CLR, CMD_CLR_STAT: ;
          default:       rd_status_q <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flc_store.sv
module flc_store #(
  parameter int NUM_BLOCKS    = 4,
  parameter int WORDS_PER_BLK = 4,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int WORD_W = $clog2(WORDS_PER_BLK),
  localparam int ADDR_W = BLK_W + WORD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_i,
  input  logic                  erase_i,
  input  logic                  erase_all_i,
  input  logic                  lock_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_BLOCKS-1:0] locks_o
);
  logic [NUM_BLOCKS-1:0][WORDS_PER_BLK-1:0][7:0] mem_q;
  logic [NUM_BLOCKS-1:0]                         lock_q;
  logic [BLK_W-1:0]                              blk;
  logic [WORD_W-1:0]                             wrd;

  assign blk = addr_i[ADDR_W-1:WORD_W];
  assign wrd = addr_i[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '1;
      lock_q <= '1;
    end else begin
      if (prog_i) mem_q[blk][wrd] <= mem_q[blk][wrd] & wdata_i;
      if (erase_i) begin
        mem_q[blk]  <= '1;
        lock_q[blk] <= 1'b0;
      end
      if (erase_all_i) begin
        for (int b = 0; b < NUM_BLOCKS; b++)
          if (!lock_q[b]) mem_q[b] <= '1;
      end
      if (lock_i) lock_q[blk] <= 1'b1;
    end
  end

  assign rdata_o = mem_q[blk][wrd];
  assign locks_o = lock_q;
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flc_pkg::*;
#(
  parameter int NUM_BLOCKS    = 4,
  parameter int WORDS_PER_BLK = 4,
  parameter int BUSY_CYCLES   = 4,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int WORD_W = $clog2(WORDS_PER_BLK),
  localparam int ADDR_W = BLK_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              vpp_low_i,
  output logic [7:0]        rdata_o,
  output logic              ready_o
);
  req_t                  req_w;
  logic                  pend_w, rd_status_w, busy_w;
  logic [NUM_BLOCKS-1:0] locks_w;
  logic [7:0]            arr_rdata_w;
  logic                  blk_locked_w, refuse_w, abort_w;
  logic                  prog_go_w, erase_go_w, erase_all_go_w;
  logic                  wp_q, err_erase_q, err_write_q, err_vpp_q;

  flc_cmd_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .busy_i(busy_w), .req_o(req_w), .pend_o(pend_w), .rd_status_o(rd_status_w)
  );

  flc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(prog_go_w | erase_go_w | erase_all_go_w), .busy_o(busy_w)
  );

  flc_store #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLK(WORDS_PER_BLK)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_i(prog_go_w), .erase_i(erase_go_w), .erase_all_i(erase_all_go_w),
    .lock_i(req_w.lock), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(arr_rdata_w), .locks_o(locks_w)
  );

  assign blk_locked_w   = locks_w[addr_i[ADDR_W-1:WORD_W]];
  // Lock refusal has priority over a supply abort
  assign refuse_w       = (req_w.prog | req_w.erase) && wp_q && blk_locked_w;
  assign abort_w        = (req_w.prog | req_w.erase | req_w.erase_all) && vpp_low_i && !refuse_w;
  assign prog_go_w      = req_w.prog  && !refuse_w && !vpp_low_i;
  assign erase_go_w     = req_w.erase && !refuse_w && !vpp_low_i;
  assign erase_all_go_w = req_w.erase_all && !vpp_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q        <= 1'b1;
      err_erase_q <= 1'b0;
      err_write_q <= 1'b0;
      err_vpp_q   <= 1'b0;
    end else begin
      if (req_w.wp_set) wp_q <= 1'b1;
      if (req_w.wp_clr) wp_q <= 1'b0;
      if (req_w.clr_stat) begin
        err_erase_q <= 1'b0;
        err_write_q <= 1'b0;
        err_vpp_q   <= 1'b0;
      end else begin
        if (req_w.bad || refuse_w) begin
          err_erase_q <= 1'b1;
          err_write_q <= 1'b1;
        end
        if (abort_w) begin
          err_vpp_q <= 1'b1;
          if (req_w.prog) err_write_q <= 1'b1;
          else            err_erase_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o = !busy_w;
  assign rdata_o = rd_status_w
                 ? {!busy_w, 1'b0, err_erase_q, err_write_q, err_vpp_q, 3'b000}
                 : arr_rdata_w;
endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
  parameter int NUM_BLOCKS  = 4,
  parameter int BUSY_CYCLES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [7:0]            wdata_i,
  input logic                  ready_o,
  input logic                  pend_i,
  input logic                  refuse_i,
  input logic                  err_e_i,
  input logic                  err_w_i,
  input logic                  err_v_i,
  input logic [NUM_BLOCKS-1:0] locks_i
);
  int   low_q;
  logic clr_cmd;

  assign clr_cmd = wr_en_i && ready_o && !pend_i && (wdata_i == 8'h50);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_q <= 0;
    else if (ready_o)  low_q <= 0;
    else               low_q <= low_q + 1;
  end

  // R3: busy window length is exact
  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> low_q == BUSY_CYCLES);

  // R5: refusal leaves ready with both error flags
  p_refuse_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_i |=> ready_o && err_e_i && err_w_i);

  // R9: error flags are sticky until clear
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_e_i || err_w_i) && !clr_cmd |=> (err_e_i || err_w_i));

  // R9: clear command wipes every error flag
  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> !err_e_i && !err_w_i && !err_v_i);

  // R10: lock bits cannot move while busy
  p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(locks_i));
endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
  .ready_o(ready_o), .pend_i(pend_w), .refuse_i(refuse_w),
  .err_e_i(err_erase_q), .err_w_i(err_write_q), .err_v_i(err_vpp_q),
  .locks_i(locks_w)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;
  localparam int BUSY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       vpp_low = 1'b0;
  logic [7:0] rdata;
  logic       ready;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(4), .WORDS_PER_BLK(4), .BUSY_CYCLES(BUSY)) u_flash_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .vpp_low_i(vpp_low), .rdata_o(rdata), .ready_o(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic prog(input logic [3:0] a, input logic [7:0] d);
    wr(a, 8'h10); wr(a, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic rd_arr(input logic [3:0] a, output logic [7:0] v);
    wr(a, 8'hFF);
    addr = a; #1;
    v = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 ready after reset", ready, 1);
    addr = 4'd0; #1;
    chk("R1 array read after reset", rdata, 8'hFF);
    wr(0, 8'h70);
    chk("R1 R2 status after reset", rdata, 8'h80);
    prog(1, 8'hFF);
    chk("R5 locked probe keeps ready", ready, 1);
    chk("R5 locked probe status", rdata, 8'hB0);
    wr(0, 8'h50);
    chk("R9 clear status", rdata, 8'h80);
    rd_arr(1, v);
    chk("R5 refused data unchanged", v, 8'hFF);
  endtask

  task automatic t_program;
    int n; logic [7:0] v;
    wr(0, 8'h47);
    prog(5, 8'h3C);
    busy_len(n);
    chk("R3 R6 busy length", n, BUSY);
    chk("R12 status after program", rdata, 8'h80);
    rd_arr(5, v);
    chk("R12 R3 array read", v, 8'h3C);
    prog(5, 8'h0F);
    busy_len(n);
    rd_arr(5, v);
    chk("R3 AND programming", v, 8'h0C);
  endtask

  task automatic t_erase_lock;
    int n; logic [7:0] v;
    wr(4, 8'h20); wr(4, 8'hD0);
    busy_len(n);
    chk("R4 erase busy length", n, BUSY);
    rd_arr(5, v);
    chk("R4 erased word", v, 8'hFF);
    wr(0, 8'h57);
    prog(6, 8'hFF);
    chk("R4 R5 unlocked after erase runs", ready, 0);
    busy_len(n);
    chk("R5 unlocked probe status", rdata, 8'h80);
    wr(4, 8'h77); wr(4, 8'h00);
    prog(6, 8'hFF);
    chk("R7 relocked ready", ready, 1);
    chk("R7 relocked probe status", rdata, 8'hB0);
    wr(0, 8'h50);
  endtask

  task automatic t_erase_all;
    int n; logic [7:0] v;
    wr(0, 8'h47);
    wr(8, 8'h20); wr(8, 8'hD0); busy_len(n);
    prog(0, 8'h12); busy_len(n);
    prog(9, 8'h34); busy_len(n);
    wr(0, 8'h57);
    wr(0, 8'hA7);
    busy_len(n);
    chk("R8 erase-all busy length", n, BUSY);
    chk("R8 erase-all status", rdata, 8'h80);
    rd_arr(0, v);
    chk("R8 locked block kept", v, 8'h12);
    rd_arr(9, v);
    chk("R8 unlocked block erased", v, 8'hFF);
  endtask

  task automatic t_invalid;
    int n;
    wr(0, 8'h33);
    chk("R9 bad code flags", rdata, 8'hB0);
    chk("R9 bad code no busy", ready, 1);
    wr(0, 8'h70);
    chk("R9 sticky after read status", rdata, 8'hB0);
    prog(8, 8'hF0);
    busy_len(n);
    chk("R9 sticky after program", rdata, 8'hB0);
    wr(0, 8'h50);
    chk("R9 cleared", rdata, 8'h80);
  endtask

  task automatic t_busy_ignore;
    int n; logic [7:0] v;
    wr(0, 8'h47);
    prog(12, 8'hAA);
    wr(0, 8'h57);
    wr(0, 8'hFF);
    busy_len(n);
    chk("R10 read mode change ignored", rdata, 8'h80);
    prog(13, 8'h0F);
    chk("R10 write-protect change ignored", ready, 0);
    busy_len(n);
    rd_arr(12, v);
    chk("R10 program during busy kept", v, 8'hAA);
  endtask

  task automatic t_vpp;
    logic [7:0] v;
    vpp_low = 1'b1;
    prog(13, 8'h00);
    chk("R11 program abort no busy", ready, 1);
    chk("R11 program abort status", rdata, 8'h98);
    rd_arr(13, v);
    chk("R11 data unchanged", v, 8'h0F);
    wr(0, 8'h50); wr(0, 8'h70);
    chk("R9 R11 clear supply flag", rdata, 8'h80);
    wr(12, 8'h20); wr(12, 8'hD0);
    chk("R11 erase abort status", rdata, 8'hA8);
    vpp_low = 1'b0;
    rd_arr(12, v);
    chk("R11 erase abort data kept", v, 8'hAA);
    wr(0, 8'h50);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_program();
    t_erase_lock();
    t_erase_all();
    t_invalid();
    t_busy_ignore();
    t_vpp();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule